// File: doc/BRIEF.md
# Selectable CRT Raster Timing Generator

This block produces the horizontal and vertical timing for a TV-type raster from a single 12 MHz clock. Every line lasts 64 µs (768 clocks), of which 40 µs carries the character page. Four static configuration inputs select the frame length and page height, interlaced or progressive scanning, separate or composite sync, and the pixel strobe rate for 40-column or 80-column text.

Besides the two sync pins, the block exports a blanking level for the colour drivers, a page display-enable, a pixel-shift strobe, the character row index and the scan line within that row, and flags for the first and last scan line of a row. A memory scheduler uses the flags to reload its row buffer. A field indicator shows which field is being scanned in interlaced operation. Every output comes from a flop, so each output reflects the counter position of the previous clock.

Top module: `crt_sync_gen`

## Requirements
- R1: A line lasts H_TOTAL clocks (768 by default). The horizontal sync is high for HS_LEN clocks (56 by default), starting at line position HS_START (640 by default), where position 0 is the first clock of the line.
- R2: `disp_en` is high when the line position is below H_ACTIVE (480 clocks by default) and the line number is inside the page. The page covers 250 lines when `cfg_long_frame`=0 and 210 lines when it is 1, counted from line 0 of the field.
- R3: With `cfg_interlace`=0 every field is a full frame of 312 lines (`cfg_long_frame`=0) or 362 lines (`cfg_long_frame`=1), and `odd_field` stays 0.
- R4: With `cfg_interlace`=1, `odd_field` toggles after each field. The field with `odd_field`=1 is one line longer. Its vertical sync starts and ends H_TOTAL/2 clocks later in the line than in the even field, so the field period is a frame and a half line.
- R5: The vertical sync rises at line VS_LINE (280 by default) and lasts exactly VS_LEN lines (3 by default), measured edge to edge at the same line position.
- R6: `blank` is high when the line position is at or beyond H_VISIBLE, or when the line number is at or beyond the page height plus V_MARGIN.
- R7: With `cfg_composite`=0, `sync_a` is the horizontal sync and `sync_b` is the vertical sync. With `cfg_composite`=1, `sync_a` is horizontal XOR vertical sync, and `sync_b` is held low because that pin is reserved for an external comparator.
- R8: With `cfg_col80`=1, `pix_en` is high on every clock (12 MHz). With `cfg_col80`=0, `pix_en` follows the repeating pattern high, high, low starting at line position 0 (8 MHz).
- R9: Inside the page, `scan_idx` = line mod ROW_LINES (10 by default) and `row_idx` = line / ROW_LINES. Outside the page both are 0.
- R10: Inside the page, `row_first` is high on scan line 0 and `row_last` is high on scan line ROW_LINES-1 of each row. Outside the page both are low.
- R11: During reset every output is 0. The first clock after reset is released presents line 0, position 0 of an even field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz timing clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_long_frame | input | 1 | 0: 312-line frame with 250-line page; 1: 362-line frame with 210-line page |
| cfg_interlace | input | 1 | 1: alternate odd and even fields with a half-line sync offset |
| cfg_composite | input | 1 | 1: composite sync on `sync_a` |
| cfg_col80 | input | 1 | 1: 12 MHz pixel strobe; 0: 8 MHz |
| sync_a | output | 1 | Horizontal sync, or composite sync |
| sync_b | output | 1 | Vertical sync; low in composite mode |
| blank | output | 1 | Colour outputs must be forced low |
| disp_en | output | 1 | Character page is being scanned |
| pix_en | output | 1 | Pixel shift strobe |
| row_idx | output | ROW_W | Character row within the page |
| scan_idx | output | SW | Scan line within the character row |
| row_first | output | 1 | First scan line of a row |
| row_last | output | 1 | Last scan line of a row |
| odd_field | output | 1 | Odd field of an interlaced frame |

## Verification
Every output is due exactly one clock after the counter position it describes, so the first clock after reset is released shows position 0 of line 0. For each configuration, the bench releases reset and queues one predicted output set per clock. A monitor removes the prediction at the falling edge following each rising edge and compares it field by field. The bench is built with a reduced raster so that several whole frames run per configuration; both fields and the half-line sync shift are reached in interlaced runs. Reset values are compared on the falling edge while reset is still asserted.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;
  typedef struct packed {
    logic long_frame;
    logic interlace;
    logic composite;
    logic col80;
  } crt_cfg_t;
endpackage

// File: rtl/crt_hcount.sv
module crt_hcount #(
  parameter int H_TOTAL   = 768,
  parameter int H_ACTIVE  = 480,
  parameter int H_VISIBLE = 624,
  parameter int HS_START  = 640,
  parameter int HS_LEN    = 56,
  localparam int HW = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic          line_end,
  output logic          h_act,
  output logic          h_vis,
  output logic          h_sync,
  output logic          pix_ok
);
  logic [1:0] phase;

  assign line_end = (int'(hcnt) == H_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt  <= '0;
      phase <= '0;
    end else begin
      hcnt  <= line_end ? '0 : hcnt + 1'b1;
      // divide-by-three phase for the 8 MHz strobe, realigned every line
      phase <= (line_end || phase == 2'd2) ? 2'd0 : phase + 2'd1;
    end
  end

  assign h_act  = int'(hcnt) < H_ACTIVE;
  assign h_vis  = int'(hcnt) < H_VISIBLE;
  assign h_sync = (int'(hcnt) >= HS_START) && (int'(hcnt) < HS_START + HS_LEN);
  assign pix_ok = (phase != 2'd2);
endmodule

// File: rtl/crt_vcount.sv
module crt_vcount
  import crt_timing_pkg::*;
#(
  parameter int H_TOTAL   = 768,
  parameter int V_TOTAL_A = 312,
  parameter int V_ACT_A   = 250,
  parameter int V_TOTAL_B = 362,
  parameter int V_ACT_B   = 210,
  parameter int V_MARGIN  = 16,
  parameter int VS_LINE   = 280,
  parameter int VS_LEN    = 3,
  parameter int ROW_LINES = 10,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL_B + 2),
  localparam int SW = $clog2(ROW_LINES),
  localparam int RW = $clog2(V_TOTAL_B / ROW_LINES + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  crt_cfg_t      cfg,
  input  logic [HW-1:0] hcnt,
  input  logic          line_end,
  output logic          odd,
  output logic          v_act,
  output logic          v_vis,
  output logic          v_sync,
  output logic [RW-1:0] row,
  output logic [SW-1:0] scan
);
  logic [VW-1:0] vcnt;
  logic          vs_q;
  int            page_lines;
  int            last_line;
  int            vs_hpos;
  logic          field_end;
  logic          vs_on;
  logic          vs_off;

  always_comb begin
    page_lines = cfg.long_frame ? V_ACT_B : V_ACT_A;
    last_line  = (cfg.long_frame ? V_TOTAL_B : V_TOTAL_A) - 1
               + ((cfg.interlace && odd) ? 1 : 0);
    vs_hpos    = (cfg.interlace && odd) ? H_TOTAL / 2 : 0;
  end

  assign field_end = line_end && (int'(vcnt) == last_line);
  assign vs_on     = (int'(vcnt) == VS_LINE) && (int'(hcnt) == vs_hpos);
  assign vs_off    = (int'(vcnt) == VS_LINE + VS_LEN) && (int'(hcnt) == vs_hpos);
  assign v_sync    = vs_on || (vs_q && !vs_off);
  assign v_act     = int'(vcnt) < page_lines;
  assign v_vis     = int'(vcnt) < page_lines + V_MARGIN;

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt <= '0;
      odd  <= 1'b0;
      row  <= '0;
      scan <= '0;
      vs_q <= 1'b0;
    end else begin
      vs_q <= v_sync;
      if (field_end) begin
        vcnt <= '0;
        row  <= '0;
        scan <= '0;
        odd  <= cfg.interlace && !odd;
      end else if (line_end) begin
        vcnt <= vcnt + 1'b1;
        if (int'(scan) == ROW_LINES - 1) begin
          scan <= '0;
          row  <= row + 1'b1;
        end else begin
          scan <= scan + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crt_sync_gen.sv
module crt_sync_gen
  import crt_timing_pkg::*;
#(
  parameter int H_TOTAL   = 768,
  parameter int H_ACTIVE  = 480,
  parameter int H_VISIBLE = 624,
  parameter int HS_START  = 640,
  parameter int HS_LEN    = 56,
  parameter int V_TOTAL_A = 312,
  parameter int V_ACT_A   = 250,
  parameter int V_TOTAL_B = 362,
  parameter int V_ACT_B   = 210,
  parameter int V_MARGIN  = 16,
  parameter int VS_LINE   = 280,
  parameter int VS_LEN    = 3,
  parameter int ROW_LINES = 10,
  localparam int HW    = $clog2(H_TOTAL),
  localparam int SW    = $clog2(ROW_LINES),
  localparam int ROW_W = $clog2(V_TOTAL_B / ROW_LINES + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_long_frame,
  input  logic             cfg_interlace,
  input  logic             cfg_composite,
  input  logic             cfg_col80,
  output logic             sync_a,
  output logic             sync_b,
  output logic             blank,
  output logic             disp_en,
  output logic             pix_en,
  output logic [ROW_W-1:0] row_idx,
  output logic [SW-1:0]    scan_idx,
  output logic             row_first,
  output logic             row_last,
  output logic             odd_field
);
  crt_cfg_t         cfg;
  logic [HW-1:0]    hcnt;
  logic             line_end, h_act, h_vis, h_sync, pix_ok;
  logic             odd, v_act, v_vis, v_sync;
  logic [ROW_W-1:0] row;
  logic [SW-1:0]    scan;

  assign cfg = '{long_frame: cfg_long_frame, interlace: cfg_interlace,
                 composite: cfg_composite, col80: cfg_col80};

  crt_hcount #(
    .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .H_VISIBLE(H_VISIBLE),
    .HS_START(HS_START), .HS_LEN(HS_LEN)
  ) u_h (
    .clk(clk), .rst(rst), .hcnt(hcnt), .line_end(line_end),
    .h_act(h_act), .h_vis(h_vis), .h_sync(h_sync), .pix_ok(pix_ok)
  );

  crt_vcount #(
    .H_TOTAL(H_TOTAL), .V_TOTAL_A(V_TOTAL_A), .V_ACT_A(V_ACT_A),
    .V_TOTAL_B(V_TOTAL_B), .V_ACT_B(V_ACT_B), .V_MARGIN(V_MARGIN),
    .VS_LINE(VS_LINE), .VS_LEN(VS_LEN), .ROW_LINES(ROW_LINES)
  ) u_v (
    .clk(clk), .rst(rst), .cfg(cfg), .hcnt(hcnt), .line_end(line_end),
    .odd(odd), .v_act(v_act), .v_vis(v_vis), .v_sync(v_sync),
    .row(row), .scan(scan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a    <= 1'b0;
      sync_b    <= 1'b0;
      blank     <= 1'b0;
      disp_en   <= 1'b0;
      pix_en    <= 1'b0;
      row_idx   <= '0;
      scan_idx  <= '0;
      row_first <= 1'b0;
      row_last  <= 1'b0;
      odd_field <= 1'b0;
    end else begin
      sync_a    <= cfg.composite ? (h_sync ^ v_sync) : h_sync;
      sync_b    <= !cfg.composite && v_sync;
      blank     <= !(h_vis && v_vis);
      disp_en   <= h_act && v_act;
      pix_en    <= cfg.col80 || pix_ok;
      row_idx   <= v_act ? row : '0;
      scan_idx  <= v_act ? scan : '0;
      row_first <= v_act && (scan == '0);
      row_last  <= v_act && (int'(scan) == ROW_LINES - 1);
      odd_field <= odd;
    end
  end
endmodule

// File: rtl/crt_sync_gen_chk.sv
module crt_sync_gen_chk #(
  parameter int ROW_LINES = 10,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_composite,
  input logic          cfg_col80,
  input logic          sync_a,
  input logic          sync_b,
  input logic          blank,
  input logic          disp_en,
  input logic          pix_en,
  input logic          row_first,
  input logic          row_last,
  input logic [SW-1:0] scan_idx
);
  assert_page_visible_R6: assert property (@(posedge clk) disable iff (rst)
    disp_en |-> !blank);

  assert_vpin_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_composite) |-> !sync_b);

  assert_hsync_off_page_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_composite) && sync_a) |-> !disp_en);

  assert_no_double_gap_R8: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> pix_en);

  assert_full_rate_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_col80) && !$past(rst)) |-> pix_en);

  assert_first_at_zero_R10: assert property (@(posedge clk) disable iff (rst)
    row_first |-> (scan_idx == '0));

  assert_flags_apart_R10: assert property (@(posedge clk) disable iff (rst)
    (ROW_LINES > 1 && row_first) |-> !row_last);
endmodule

bind crt_sync_gen crt_sync_gen_chk #(.ROW_LINES(ROW_LINES), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .cfg_composite(cfg_composite), .cfg_col80(cfg_col80),
  .sync_a(sync_a), .sync_b(sync_b), .blank(blank), .disp_en(disp_en),
  .pix_en(pix_en), .row_first(row_first), .row_last(row_last),
  .scan_idx(scan_idx)
);

// File: tb/tb_crt_sync_gen.sv
`timescale 1ns/1ps
module tb_crt_sync_gen;
  localparam int HT = 24, HA = 12, HV = 15, HSS = 17, HSL = 3;
  localparam int VTA = 12, VAA = 6, VTB = 16, VAB = 3, VM = 1;
  localparam int VSL = 9, VSN = 2, RL = 3;
  localparam int SW = $clog2(RL);
  localparam int RW = $clog2(VTB / RL + 2);

  typedef struct packed {
    logic sa, sb, bl, de, px, rf, rl, od;
    logic [RW-1:0] row;
    logic [SW-1:0] scan;
  } exp_t;

  logic clk = 0, rst = 1;
  logic lf = 0, il = 0, cp = 0, c80 = 0;
  logic sync_a, sync_b, blank, disp_en, pix_en, row_first, row_last, odd_field;
  logic [RW-1:0] row_idx;
  logic [SW-1:0] scan_idx;

  exp_t q[$];
  exp_t e;
  logic mon_on = 0;
  int n_chk = 0, n_fail = 0;
  int mh, mv, mf;

  always #2.5 clk = ~clk;

  crt_sync_gen #(
    .H_TOTAL(HT), .H_ACTIVE(HA), .H_VISIBLE(HV), .HS_START(HSS), .HS_LEN(HSL),
    .V_TOTAL_A(VTA), .V_ACT_A(VAA), .V_TOTAL_B(VTB), .V_ACT_B(VAB),
    .V_MARGIN(VM), .VS_LINE(VSL), .VS_LEN(VSN), .ROW_LINES(RL)
  ) dut (
    .clk(clk), .rst(rst), .cfg_long_frame(lf), .cfg_interlace(il),
    .cfg_composite(cp), .cfg_col80(c80), .sync_a(sync_a), .sync_b(sync_b),
    .blank(blank), .disp_en(disp_en), .pix_en(pix_en), .row_idx(row_idx),
    .scan_idx(scan_idx), .row_first(row_first), .row_last(row_last),
    .odd_field(odd_field)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // expected outputs for bench position (mh, mv, mf), built from the requirements
  function automatic exp_t predict();
    exp_t r;
    int page, off, pos, hs, vs;
    logic inpage;
    page   = lf ? VAB : VAA;
    off    = (il && mf != 0) ? HT / 2 : 0;
    pos    = mv * HT + mh;
    hs     = (mh >= HSS && mh < HSS + HSL) ? 1 : 0;
    vs     = (pos >= VSL * HT + off && pos < (VSL + VSN) * HT + off) ? 1 : 0;
    inpage = mv < page;
    r.sa   = cp ? logic'(hs ^ vs) : logic'(hs);
    r.sb   = cp ? 1'b0 : logic'(vs);
    r.bl   = (mh >= HV) || (mv >= page + VM);
    r.de   = (mh < HA) && inpage;
    r.px   = c80 || (mh % 3 != 2);
    r.rf   = inpage && (mv % RL == 0);
    r.rl   = inpage && (mv % RL == RL - 1);
    r.od   = logic'(mf);
    r.row  = inpage ? RW'(mv / RL) : '0;
    r.scan = inpage ? SW'(mv % RL) : '0;
    return r;
  endfunction

  task automatic advance();
    int lines;
    lines = (lf ? VTB : VTA) + ((il && mf != 0) ? 1 : 0);
    mh++;
    if (mh == HT) begin
      mh = 0;
      mv++;
      if (mv == lines) begin
        mv = 0;
        mf = il ? 1 - mf : 0;
      end
    end
  endtask

  // monitor: one prediction per clock, compared away from the rising edge
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      e = q.pop_front();
      chk("R1 R7 sync_a", int'(sync_a), int'(e.sa));
      chk("R5 R4 R7 sync_b", int'(sync_b), int'(e.sb));
      chk("R6 blank", int'(blank), int'(e.bl));
      chk("R2 R3 disp_en", int'(disp_en), int'(e.de));
      chk("R8 pix_en", int'(pix_en), int'(e.px));
      chk("R10 row_first", int'(row_first), int'(e.rf));
      chk("R10 row_last", int'(row_last), int'(e.rl));
      chk("R4 odd_field", int'(odd_field), int'(e.od));
      chk("R9 row_idx", int'(row_idx), int'(e.row));
      chk("R9 scan_idx", int'(scan_idx), int'(e.scan));
    end
  end

  // driver: reset, then queue the predicted outputs of n clocks
  task automatic run_cfg(logic a, logic b, logic c, logic d, int n);
    @(negedge clk);
    rst = 1; lf = a; il = b; cp = c; c80 = d;
    repeat (3) @(negedge clk);
    // R11: all outputs zero while reset is held
    chk("R11 reset outputs",
        int'({sync_a, sync_b, blank, disp_en, pix_en, row_first, row_last,
              odd_field, row_idx, scan_idx}), 0);
    rst = 0;
    mh = 0; mv = 0; mf = 0;
    for (int i = 0; i < n; i++) begin
      q.push_back(predict());
      advance();
    end
    @(posedge clk);
    mon_on = 1;
    wait (q.size() == 0);
    mon_on = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    run_cfg(1'b0, 1'b0, 1'b0, 1'b0, 3 * VTA * HT);        // short frame, separate, 40 col
    run_cfg(1'b1, 1'b0, 1'b1, 1'b1, 3 * VTB * HT);        // long frame, composite, 80 col
    run_cfg(1'b0, 1'b1, 1'b0, 1'b0, 2 * (2 * VTA + 1) * HT + 50); // interlaced
    run_cfg(1'b1, 1'b1, 1'b1, 1'b0, 2 * (2 * VTB + 1) * HT + 50); // interlaced composite
    run_cfg(1'b1, 1'b1, 1'b0, 1'b1, 2 * (2 * VTB + 1) * HT);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, actual=running expected=done");
    summary();
    $finish;
  end
endmodule